// File: doc/BRIEF.md
# External Interrupt Request Detector

This block watches six external interrupt request pins and turns qualifying activity on each pin into a sticky status flag. Every pin has a 2-bit sense selection. It picks one of four conditions: the pin held low, a falling edge, a rising edge, or either edge. A flag that is set and whose enable bit is on drives a per-line request. All line requests are also ORed into one combined request for the interrupt controller upstream.

Software reaches an enable register and a status register over a simple single-cycle register bus. The read data always shows the addressed register. A read strobe on the status register marks each flag seen as 1 as eligible for clearing. A later write of 0 to that bit then clears it. Writing 1 to a flag bit does nothing. Hardware clears flags through acknowledge inputs. A service acknowledge clears an edge-mode flag unconditionally, and clears a low-level flag only when the pin is back high. A transfer-engine acknowledge clears the flag when its keep input is 0.

Top module: `ext_irq_detector`

## Requirements
- R1: After reset, both registers read 0x00, no line request is active and the combined request is low.
- R2: The enable register (address 0) holds bits 5..0 as written and reads back with bits 7..6 equal to 0; a write takes effect on the next clock edge.
- R3: With sense code 00 (low level; line n uses sense_ctl bits 2n+1..2n), a flag is set while the synchronized pin is low, and stays set after the pin returns high.
- R4: With sense code 01, a high-to-low transition sets the flag and a low-to-high transition does not.
- R5: With sense code 10, a low-to-high transition sets the flag and a high-to-low transition does not.
- R6: With sense code 11, either transition sets the flag. Activity on one line never changes another line's flag.
- R7: Writing 1 to a status bit (address 1) has no effect on that flag.
- R8: A write of 0 to a status bit clears that flag only if the status register was read with reg_rd while the flag was 1 before the write. That arming is cancelled if a new set condition for that line occurs before the write.
- R9: In any edge mode (codes 01, 10, 11), svc_ack for line n clears flag n.
- R10: In low-level mode, svc_ack for line n clears flag n only if the synchronized pin is high; if the pin is low the flag stays set.
- R11: xfer_ack for line n clears flag n when xfer_keep[n] is 0 and has no effect when xfer_keep[n] is 1.
- R12: When a set condition and any clear event hit the same line in the same cycle, the flag ends set.
- R13: line_req[n] equals flag n AND enable bit n, and irq_any is the OR of all line_req bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 1 | Register select: 0 enable, 1 status |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (arms status bits read as 1) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Addressed register contents, combinational |
| irq_pin | input | 6 | Asynchronous request pins, idle high |
| sense_ctl | input | 12 | Per-line 2-bit sense selection |
| svc_ack | input | 6 | Per-line interrupt service acknowledge |
| xfer_ack | input | 6 | Per-line transfer-engine activation acknowledge |
| xfer_keep | input | 6 | Per-line keep select for xfer_ack (1 keeps the flag) |
| line_req | output | 6 | Per-line request, flag AND enable |
| irq_any | output | 1 | OR of all line requests |

## Verification
A pin change applied between edges passes two synchronizer stages and reaches the flag on the third rising edge. The bench therefore samples once after the second edge, where the flag must still be unchanged, and once after the third, where it must show the computed value. Acknowledges and bus writes act on the next edge and are checked at the falling edge that follows it. Read data, line_req and irq_any are combinational from registered state, so they are sampled within the same half cycle.

// File: rtl/irq_det_pkg.sv
package irq_det_pkg;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_FALL = 2'b01,
        SENSE_RISE = 2'b10,
        SENSE_BOTH = 2'b11
    } sense_e;

    localparam logic ADDR_ENABLE = 1'b0;
    localparam logic ADDR_STATUS = 1'b1;

    // Set condition for one line given the selected sense and two samples.
    function automatic logic sense_hit(sense_e mode, logic cur, logic prev);
        logic hit;
        unique case (mode)
            SENSE_LOW:  hit = !cur;
            SENSE_FALL: hit = prev && !cur;
            SENSE_RISE: hit = !prev && cur;
            default:    hit = prev ^ cur;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int unsigned W      = 6,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] cur_o,
    output logic [W-1:0] prev_o
);

    typedef struct packed {
        logic [STAGES-1:0][W-1:0] chain;
        logic [W-1:0]             prev;
    } sync_t;

    localparam logic [W-1:0] IDLE = '1;

    sync_t s_d, s_q;

    always_comb begin
        s_d          = s_q;
        s_d.chain[0] = pin_i;
        for (int s = 1; s < int'(STAGES); s++) begin
            s_d.chain[s] = s_q.chain[s-1];
        end
        s_d.prev = s_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.chain <= {STAGES{IDLE}};
            s_q.prev  <= IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign cur_o  = s_q.chain[STAGES-1];
    assign prev_o = s_q.prev;

endmodule

// File: rtl/irq_flag_cell.sv
module irq_flag_cell
    import irq_det_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sense_i,
    input  logic       cur_i,
    input  logic       prev_i,
    input  logic       svc_ack_i,
    input  logic       xfer_ack_i,
    input  logic       xfer_keep_i,
    input  logic       rd_arm_i,
    input  logic       wr_zero_i,
    output logic       flag_o
);

    typedef struct packed {
        logic flag;
        logic armed;
    } cell_t;

    cell_t c_d, c_q;
    sense_e mode;
    logic   hit, hw_clr, sw_clr;

    always_comb begin
        mode   = sense_e'(sense_i);
        hit    = sense_hit(mode, cur_i, prev_i);
        hw_clr = (svc_ack_i && ((mode != SENSE_LOW) || cur_i))
               || (xfer_ack_i && !xfer_keep_i);
        sw_clr = wr_zero_i && c_q.armed;

        c_d = c_q;
        if (hit) begin
            c_d.flag = 1'b1;
        end else if (c_q.flag && (hw_clr || sw_clr)) begin
            c_d.flag = 1'b0;
        end

        if (hit || !c_d.flag) begin
            c_d.armed = 1'b0;
        end else if (rd_arm_i && c_q.flag) begin
            c_d.armed = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign flag_o = c_q.flag;

endmodule

// File: rtl/ext_irq_detector.sv
module ext_irq_detector
    import irq_det_pkg::*;
#(
    parameter int unsigned NUM_LINES   = 6,
    parameter int unsigned REG_W       = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_addr,
    input  logic                   reg_wr,
    input  logic                   reg_rd,
    input  logic [REG_W-1:0]       reg_wdata,
    output logic [REG_W-1:0]       reg_rdata,
    input  logic [NUM_LINES-1:0]   irq_pin,
    input  logic [2*NUM_LINES-1:0] sense_ctl,
    input  logic [NUM_LINES-1:0]   svc_ack,
    input  logic [NUM_LINES-1:0]   xfer_ack,
    input  logic [NUM_LINES-1:0]   xfer_keep,
    output logic [NUM_LINES-1:0]   line_req,
    output logic                   irq_any
);

    typedef struct packed {
        logic [NUM_LINES-1:0] en;
    } regs_t;

    regs_t regs_d, regs_q;

    logic [NUM_LINES-1:0] sync_cur, sync_prev, flag_vec, en_vec, wr_zero;
    logic                 rd_status, wr_status, wr_enable;

    irq_sync #(.W(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (irq_pin),
        .cur_o  (sync_cur),
        .prev_o (sync_prev)
    );

    for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
        irq_flag_cell u_cell (
            .clk         (clk),
            .rst_n       (rst_n),
            .sense_i     (sense_ctl[2*n +: 2]),
            .cur_i       (sync_cur[n]),
            .prev_i      (sync_prev[n]),
            .svc_ack_i   (svc_ack[n]),
            .xfer_ack_i  (xfer_ack[n]),
            .xfer_keep_i (xfer_keep[n]),
            .rd_arm_i    (rd_status),
            .wr_zero_i   (wr_zero[n]),
            .flag_o      (flag_vec[n])
        );
    end

    if (REG_W > NUM_LINES) begin : g_hi
        logic unused_wdata_hi;
        assign unused_wdata_hi = ^reg_wdata[REG_W-1:NUM_LINES];
    end

    always_comb begin
        rd_status = reg_rd && (reg_addr == ADDR_STATUS);
        wr_status = reg_wr && (reg_addr == ADDR_STATUS);
        wr_enable = reg_wr && (reg_addr == ADDR_ENABLE);

        regs_d = regs_q;
        if (wr_enable) begin
            regs_d.en = reg_wdata[NUM_LINES-1:0];
        end

        for (int n = 0; n < int'(NUM_LINES); n++) begin
            wr_zero[n] = wr_status && !reg_wdata[n];
        end

        reg_rdata = (reg_addr == ADDR_STATUS) ? REG_W'(flag_vec) : REG_W'(regs_q.en);
        line_req  = flag_vec & regs_q.en;
        irq_any   = |line_req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign en_vec = regs_q.en;

endmodule

// File: rtl/irq_det_checker.sv
module irq_det_checker
    import irq_det_pkg::*;
#(
    parameter int unsigned N = 6
) (
    input logic           clk,
    input logic           rst_n,
    input logic           reg_addr,
    input logic           reg_wr,
    input logic [N-1:0]   wdata,
    input logic [2*N-1:0] sense_ctl,
    input logic [N-1:0]   svc_ack,
    input logic [N-1:0]   xfer_ack,
    input logic [N-1:0]   xfer_keep,
    input logic [N-1:0]   cur,
    input logic [N-1:0]   prev,
    input logic [N-1:0]   flags,
    input logic [N-1:0]   en
);

    logic [N-1:0] hit, clr_any, wr_one;

    always_comb begin
        for (int n = 0; n < int'(N); n++) begin
            case (sense_ctl[2*n +: 2])
                2'b00:   hit[n] = !cur[n];
                2'b01:   hit[n] = prev[n] && !cur[n];
                2'b10:   hit[n] = !prev[n] && cur[n];
                default: hit[n] = prev[n] != cur[n];
            endcase
            clr_any[n] = svc_ack[n] || (xfer_ack[n] && !xfer_keep[n])
                       || (reg_wr && reg_addr && !wdata[n]);
            wr_one[n]  = reg_wr && reg_addr && wdata[n];
        end
    end

    for (genvar n = 0; n < N; n++) begin : g_chk
        // A flag only rises after its selected condition (R3, R4, R5, R6)
        assert_flag_rise_has_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flags[n]) |-> $past(hit[n]));

        // A flag only falls after some clear request (R8, R9, R10, R11)
        assert_flag_fall_has_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(flags[n]) |-> $past(clr_any[n]));

        assert_set_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
            hit[n] |=> flags[n]);

        assert_write_one_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[n] && wr_one[n] && !svc_ack[n] && !(xfer_ack[n] && !xfer_keep[n]))
            |=> flags[n]);

        assert_enable_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr && !reg_addr) |=> (en[n] == $past(wdata[n])));
    end

endmodule

bind ext_irq_detector irq_det_checker #(.N(NUM_LINES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .wdata     (reg_wdata[NUM_LINES-1:0]),
    .sense_ctl (sense_ctl),
    .svc_ack   (svc_ack),
    .xfer_ack  (xfer_ack),
    .xfer_keep (xfer_keep),
    .cur       (sync_cur),
    .prev      (sync_prev),
    .flags     (flag_vec),
    .en        (en_vec)
);

// File: tb/sim_ext_irq_detector.sv
module sim_ext_irq_detector;

    localparam int CLK_PERIOD = 10;
    localparam int NL = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_addr = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    reg_rdata;
    logic [NL-1:0] irq_pin = '1;
    logic [11:0]   sense_ctl = '0;
    logic [NL-1:0] svc_ack = '0, xfer_ack = '0, xfer_keep = '0;
    logic [NL-1:0] line_req;
    logic          irq_any;

    int total = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ext_irq_detector u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_pin(irq_pin),
        .sense_ctl(sense_ctl), .svc_ack(svc_ack), .xfer_ack(xfer_ack),
        .xfer_keep(xfer_keep), .line_req(line_req), .irq_any(irq_any)
    );

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic peek(logic a, output logic [7:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic bus_write(logic a, logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        tick(1);
        reg_wr = 1'b0;
    endtask

    task automatic bus_read(logic a, output logic [7:0] v);
        reg_addr = a; reg_rd = 1'b1;
        #1;
        v = reg_rdata;
        tick(1);
        reg_rd = 1'b0;
    endtask

    task automatic pulse_svc(logic [NL-1:0] m);
        svc_ack = m; tick(1); svc_ack = '0;
    endtask

    // Falling-edge pulse on the masked pins, then let the flags settle.
    task automatic fall_pulse(logic [NL-1:0] m);
        irq_pin = ~m; tick(1); irq_pin = '1; tick(4);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            fails++; total++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R1 reset state
        peek(1'b1, v); chk("R1 status", v, 0);
        peek(1'b0, v); chk("R1 enable", v, 0);
        chk("R1 line_req", line_req, 0);
        chk("R1 irq_any", irq_any, 0);

        // R2 enable register width
        bus_write(1'b0, 8'hFF);
        peek(1'b0, v); chk("R2 enable FF", v, 8'h3F);
        bus_write(1'b0, 8'h00);
        peek(1'b0, v); chk("R2 enable 00", v, 8'h00);

        // Sweep all modes over all lines (R3 R4 R5 R6 R9)
        for (int m = 0; m < 4; m++) begin
            int fall_exp, rise_exp;
            fall_exp = (m == 0 || m == 1 || m == 3) ? 1 : 0;
            rise_exp = (m == 2 || m == 3) ? 1 : 0;
            sense_ctl = {NL{2'(m)}};
            tick(4);
            pulse_svc('1);
            for (int i = 0; i < NL; i++) begin
                peek(1'b1, v); chk($sformatf("R9 clear before mode %0d line %0d", m, i), v, 0);
                irq_pin[i] = 1'b0;
                tick(2);
                peek(1'b1, v); chk($sformatf("R3 latency mode %0d line %0d", m, i), v, 0);
                tick(1);
                peek(1'b1, v);
                chk($sformatf("R4 fall mode %0d line %0d", m, i), v, fall_exp << i);
                irq_pin[i] = 1'b1;
                tick(3);
                peek(1'b1, v);
                chk($sformatf("R5 R6 rise mode %0d line %0d", m, i), v, (fall_exp | rise_exp) << i);
                pulse_svc(6'(1 << i));
                peek(1'b1, v); chk($sformatf("R9 svc mode %0d line %0d", m, i), v, 0);
            end
        end

        // R13 masking
        sense_ctl = {NL{2'b01}};
        tick(2);
        fall_pulse(6'h0F);
        for (int k = 0; k < 5; k++) begin
            logic [5:0] p;
            p = 6'(k * 13 + 5);
            bus_write(1'b0, {2'b11, p});
            peek(1'b0, v); chk("R2 enable readback", v, p);
            chk("R13 line_req", line_req, p & 6'h0F);
            chk("R13 irq_any", irq_any, (|(p & 6'h0F)) ? 1 : 0);
        end
        bus_write(1'b0, 8'h00);
        pulse_svc('1);

        // R7 and R8 software clear rules
        fall_pulse(6'h1C);
        peek(1'b1, v); chk("R8 setup", v, 8'h1C);
        bus_write(1'b1, 8'hFF);
        peek(1'b1, v); chk("R7 write ones", v, 8'h1C);
        bus_write(1'b1, 8'h00);
        peek(1'b1, v); chk("R8 write zero unread", v, 8'h1C);
        bus_read(1'b1, v); chk("R8 read value", v, 8'h1C);
        bus_write(1'b1, 8'hFB);
        peek(1'b1, v); chk("R8 armed clear", v, 8'h18);
        fall_pulse(6'h08);
        bus_write(1'b1, 8'hF7);
        peek(1'b1, v); chk("R8 arm cancelled", v, 8'h18);
        bus_write(1'b1, 8'hEF);
        peek(1'b1, v); chk("R8 armed clear line 4", v, 8'h08);
        pulse_svc('1);

        // R11 transfer acknowledge
        fall_pulse(6'h02);
        xfer_keep = 6'h02; xfer_ack = 6'h02; tick(1); xfer_ack = '0;
        peek(1'b1, v); chk("R11 keep=1", v, 8'h02);
        xfer_keep = '0; xfer_ack = 6'h02; tick(1); xfer_ack = '0;
        peek(1'b1, v); chk("R11 keep=0", v, 8'h00);

        // R12 set beats clear in the same cycle
        fall_pulse(6'h01);
        irq_pin[0] = 1'b0;
        tick(2);
        svc_ack = 6'h01; tick(1); svc_ack = '0;
        peek(1'b1, v); chk("R12 set wins", v, 8'h01);
        irq_pin[0] = 1'b1;
        tick(4);
        pulse_svc(6'h01);
        peek(1'b1, v); chk("R9 svc after R12", v, 8'h00);

        // R10 low-level acknowledge depends on pin
        sense_ctl = '0;
        irq_pin[5] = 1'b0;
        tick(3);
        pulse_svc(6'h20);
        peek(1'b1, v); chk("R10 svc while low", v, 8'h20);
        irq_pin[5] = 1'b1;
        tick(3);
        peek(1'b1, v); chk("R3 hold after high", v, 8'h20);
        pulse_svc(6'h20);
        peek(1'b1, v); chk("R10 svc while high", v, 8'h00);

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule